// File: doc/BRIEF.md
# Byte-Accessed Modulo Timer Counter

This block is a 16-bit timer counter whose upper limit is set by a programmable modulo value, with all software access going through a narrow 8-bit register port. The counter steps once for each cycle in which the prescaled tick input is high. In edge mode it climbs to the modulo value and then returns to zero. In centre mode it climbs to the modulo value, reverses, and descends back to zero. Each period end raises an overflow flag. That flag can drive an interrupt request.

Because the bus is only one byte wide, two mechanisms keep the 16-bit quantities consistent. The modulo value is loaded through a two-byte staging register. It only becomes active once both halves are in, and the overflow flag cannot be set while a load is half done. Counter reads pass through a coherency buffer. Reading one byte captures the other byte at the same instant, so the second read returns a matching pair. A debug input freezes both the counter and the coherency buffer, so a debugger can read freely without disturbing either.

Register map (address, meaning): 0 control/status, 1 counter high byte, 2 counter low byte, 3 modulo high byte, 4 modulo low byte. Control/status bits: bit 7 overflow flag, bit 6 interrupt enable, bit 5 centre mode. All other bits read as 0.

Top module: `tmr_modulo_timer`

## Requirements
- R1: After reset the counter, the modulo value and the control/status register all read 0, the interrupt output is low and no counter byte is held in the coherency buffer.
- R2: In edge mode (status bit 5 = 0) the counter changes only on cycles with `tick` high. On a tick while the count equals a nonzero modulo value, it goes to 0 and sets the overflow flag (status bit 7).
- R3: With a modulo value of 0 the counter runs through the full 16-bit range. The tick at 0xFFFF takes it to 0 and sets the overflow flag.
- R4: In centre mode (bit 5 = 1) the counter counts down after reaching the modulo value. On a tick at 0 while counting down it goes to 1 and sets the overflow flag, so flags are 2×modulo ticks apart.
- R5: A modulo write reaches the active modulo value only after both bytes have been written, in either order. Until then, reads of addresses 3/4 and the counter's wrap point still use the previous value.
- R6: While only one modulo byte has been written, an overflow event still wraps the counter but does not set the flag.
- R7: A read of the counter high byte returns the live high byte and captures the low byte. The next low-byte read returns the captured value and releases the buffer.
- R8: A read of the low byte with nothing held returns the live low byte and captures the high byte. The next high-byte read returns the captured value.
- R9: While `dbg_freeze` is high the counter does not move and the coherency buffer neither captures nor releases, even when counter bytes are read.
- R10: The overflow flag clears only when a control/status write with bit 7 = 0 follows a read of that register that saw the flag set. A write of 0 without that read leaves the flag set.
- R11: `irq` is high exactly when the overflow flag and the interrupt enable (bit 6) are both set.
- R12: Any write to address 1 or 2 sets the counter to 0, restarts centre mode counting upward, and empties the coherency buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Count enable, one cycle per counting step |
| dbg_freeze | input | 1 | Debug freeze of counter and read buffer |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (read side effects) |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from address |
| irq | output | 1 | Overflow interrupt request |

## Verification
Read data is combinational, so a read returns its value in the cycle its strobe is high. Any capture or release in the coherency buffer takes effect at that cycle's rising edge. Writes, ticks, flag changes and modulo commits all appear one edge after the cycle that carries them. The bench therefore drives strobes and ticks at falling edges, samples `rdata` shortly after driving a read, and observes every result at the next falling edge. Each counter expectation is a tick count worked out by hand from the mode and the modulo value.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef logic [2:0] addr_t;

    localparam addr_t ADDR_STAT   = 3'd0;
    localparam addr_t ADDR_CNT_HI = 3'd1;
    localparam addr_t ADDR_CNT_LO = 3'd2;
    localparam addr_t ADDR_MOD_HI = 3'd3;
    localparam addr_t ADDR_MOD_LO = 3'd4;

    localparam int FLAG_BIT = 7;
    localparam int IE_BIT   = 6;
    localparam int CTR_BIT  = 5;

    typedef enum logic [1:0] {
        LAT_EMPTY   = 2'd0,
        LAT_HI_HELD = 2'd1,
        LAT_LO_HELD = 2'd2
    } lat_e;
endpackage

// File: rtl/tmr_mod_reg.sv
module tmr_mod_reg #(
    parameter int CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_hi,
    input  logic               wr_lo,
    input  logic [CNT_W/2-1:0] wdata,
    output logic [CNT_W-1:0]   mod_val,
    output logic               pend
);
    localparam int BW = CNT_W / 2;

    typedef struct packed {
        logic [BW-1:0]    stage_hi;
        logic [BW-1:0]    stage_lo;
        logic             seen_hi;
        logic             seen_lo;
        logic [CNT_W-1:0] active;
    } mod_st_t;

    mod_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_hi) begin
            st_d.stage_hi = wdata;
            if (st_q.seen_lo) begin
                st_d.active  = {wdata, st_q.stage_lo};
                st_d.seen_lo = 1'b0;
                st_d.seen_hi = 1'b0;
            end else begin
                st_d.seen_hi = 1'b1;
            end
        end else if (wr_lo) begin
            st_d.stage_lo = wdata;
            if (st_q.seen_hi) begin
                st_d.active  = {st_q.stage_hi, wdata};
                st_d.seen_lo = 1'b0;
                st_d.seen_hi = 1'b0;
            end else begin
                st_d.seen_lo = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mod_val = st_q.active;
    assign pend    = st_q.seen_hi | st_q.seen_lo;
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             freeze,
    input  logic             centre,
    input  logic             clr,
    input  logic [CNT_W-1:0] mod_val,
    output logic [CNT_W-1:0] cnt,
    output logic             down,
    output logic             wrap_evt
);
    localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] ONE      = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             down;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic [CNT_W-1:0] term;
    logic             step;

    assign term = (mod_val == '0) ? ALL_ONES : mod_val;
    assign step = tick & ~freeze & ~clr;

    always_comb begin
        st_d     = st_q;
        wrap_evt = 1'b0;
        if (clr) begin
            st_d.cnt  = '0;
            st_d.down = 1'b0;
        end else if (step) begin
            if (!centre) begin
                st_d.down = 1'b0;
                if (st_q.cnt == term) begin
                    st_d.cnt = '0;
                    wrap_evt = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt + ONE;
                end
            end else if (st_q.down) begin
                if (st_q.cnt == '0) begin
                    st_d.cnt  = ONE;
                    st_d.down = 1'b0;
                    wrap_evt  = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt - ONE;
                end
            end else begin
                if (st_q.cnt == term) begin
                    st_d.cnt  = st_q.cnt - ONE;
                    st_d.down = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt + ONE;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt  = st_q.cnt;
    assign down = st_q.down;
endmodule

// File: rtl/tmr_rd_latch.sv
module tmr_rd_latch
    import tmr_pkg::*;
#(
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_hi,
    input  logic          rd_lo,
    input  logic          freeze,
    input  logic          clr,
    input  logic [BW-1:0] cnt_hi,
    input  logic [BW-1:0] cnt_lo,
    output logic [BW-1:0] hi_byte,
    output logic [BW-1:0] lo_byte,
    output lat_e          state
);
    typedef struct packed {
        lat_e          state;
        logic [BW-1:0] held;
    } lat_st_t;

    lat_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.state = LAT_EMPTY;
            st_d.held  = '0;
        end else if (!freeze) begin
            if (rd_hi) begin
                if (st_q.state == LAT_HI_HELD) begin
                    st_d.state = LAT_EMPTY;
                end else begin
                    st_d.state = LAT_LO_HELD;
                    st_d.held  = cnt_lo;
                end
            end else if (rd_lo) begin
                if (st_q.state == LAT_LO_HELD) begin
                    st_d.state = LAT_EMPTY;
                end else begin
                    st_d.state = LAT_HI_HELD;
                    st_d.held  = cnt_hi;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.state <= LAT_EMPTY;
            st_q.held  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hi_byte = (st_q.state == LAT_HI_HELD) ? st_q.held : cnt_hi;
    assign lo_byte = (st_q.state == LAT_LO_HELD) ? st_q.held : cnt_lo;
    assign state   = st_q.state;
endmodule

// File: rtl/tmr_modulo_timer.sv
module tmr_modulo_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                dbg_freeze,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [2:0]          addr,
    input  logic [CNT_W/2-1:0]  wdata,
    output logic [CNT_W/2-1:0]  rdata,
    output logic                irq
);
    localparam int BW = CNT_W / 2;

    typedef struct packed {
        logic flag;
        logic armed;
        logic ie;
        logic centre;
    } stat_st_t;

    stat_st_t st_d, st_q;

    logic             wr_stat, rd_stat, wr_cnt;
    logic             wr_mhi, wr_mlo, rd_chi, rd_clo;
    logic [CNT_W-1:0] mod_val, cnt;
    logic             pend, down, wrap_evt;
    logic [BW-1:0]    hi_byte, lo_byte;
    lat_e             lat_state;

    assign wr_stat = wr_en & (addr == ADDR_STAT);
    assign rd_stat = rd_en & (addr == ADDR_STAT);
    assign wr_cnt  = wr_en & ((addr == ADDR_CNT_HI) | (addr == ADDR_CNT_LO));
    assign wr_mhi  = wr_en & (addr == ADDR_MOD_HI);
    assign wr_mlo  = wr_en & (addr == ADDR_MOD_LO);
    assign rd_chi  = rd_en & (addr == ADDR_CNT_HI);
    assign rd_clo  = rd_en & (addr == ADDR_CNT_LO);

    tmr_mod_reg #(.CNT_W(CNT_W)) u_mod (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_hi   (wr_mhi),
        .wr_lo   (wr_mlo),
        .wdata   (wdata),
        .mod_val (mod_val),
        .pend    (pend)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .freeze   (dbg_freeze),
        .centre   (st_q.centre),
        .clr      (wr_cnt),
        .mod_val  (mod_val),
        .cnt      (cnt),
        .down     (down),
        .wrap_evt (wrap_evt)
    );

    tmr_rd_latch #(.BW(BW)) u_lat (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_hi   (rd_chi),
        .rd_lo   (rd_clo),
        .freeze  (dbg_freeze),
        .clr     (wr_cnt),
        .cnt_hi  (cnt[CNT_W-1:BW]),
        .cnt_lo  (cnt[BW-1:0]),
        .hi_byte (hi_byte),
        .lo_byte (lo_byte),
        .state   (lat_state)
    );

    always_comb begin
        st_d = st_q;
        if (rd_stat && st_q.flag) st_d.armed = 1'b1;
        if (wr_stat) begin
            st_d.ie     = wdata[IE_BIT];
            st_d.centre = wdata[CTR_BIT];
            st_d.armed  = 1'b0;
            if (!wdata[FLAG_BIT] && st_q.armed && st_q.flag) st_d.flag = 1'b0;
        end
        if (wrap_evt && !pend) st_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_STAT: begin
                rdata[FLAG_BIT] = st_q.flag;
                rdata[IE_BIT]   = st_q.ie;
                rdata[CTR_BIT]  = st_q.centre;
            end
            ADDR_CNT_HI: rdata = hi_byte;
            ADDR_CNT_LO: rdata = lo_byte;
            ADDR_MOD_HI: rdata = mod_val[CNT_W-1:BW];
            ADDR_MOD_LO: rdata = mod_val[BW-1:0];
            default:     rdata = '0;
        endcase
    end

    assign irq = st_q.flag & st_q.ie;
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             dbg_freeze,
    input logic             wr_en,
    input logic [2:0]       addr,
    input logic             centre,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] mod_val,
    input logic             pend,
    input logic             down,
    input logic             flag,
    input lat_e             lat_state
);
    logic cnt_wr;
    assign cnt_wr = wr_en & ((addr == ADDR_CNT_HI) | (addr == ADDR_CNT_LO));

    assert_up_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !dbg_freeze && !centre && !cnt_wr && mod_val != '0 && cnt == mod_val)
        |=> (cnt == '0));

    assert_centre_turn_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !dbg_freeze && centre && !cnt_wr && down && cnt == '0)
        |=> (cnt == {{(CNT_W-1){1'b0}}, 1'b1} && !down));

    assert_no_flag_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> !$past(pend));

    assert_freeze_cnt_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_freeze && !cnt_wr) |=> $stable(cnt));

    assert_freeze_latch_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_freeze && !cnt_wr) |=> $stable(lat_state));

    assert_flag_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag) |-> $past(wr_en && addr == ADDR_STAT));

    assert_cnt_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (cnt == '0 && lat_state == LAT_EMPTY && !down));
endmodule

bind tmr_modulo_timer tmr_checker #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .dbg_freeze (dbg_freeze),
    .wr_en      (wr_en),
    .addr       (addr),
    .centre     (st_q.centre),
    .cnt        (cnt),
    .mod_val    (mod_val),
    .pend       (pend),
    .down       (down),
    .flag       (st_q.flag),
    .lat_state  (lat_state)
);

// File: tb/tb_tmr_modulo_timer.sv
module tb_tmr_modulo_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       dbg_freeze = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       irq;

    int errors = 0;
    int checks = 0;

    tmr_modulo_timer dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .dbg_freeze(dbg_freeze),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq(irq)
    );

    always #5 clk = ~clk;

    task automatic check_eq(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%04h expected=0x%04h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic read_cnt(output logic [15:0] v);
        logic [7:0] h, l;
        bus_read(3'd1, h);
        bus_read(3'd2, l);
        v = {h, l};
    endtask

    task automatic ticks(input int n);
        repeat (n) begin
            @(negedge clk);
            tick = 1'b1;
        end
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic set_mod(input logic [15:0] m);
        bus_write(3'd3, m[15:8]);
        bus_write(3'd4, m[7:0]);
    endtask

    task automatic clear_flag(input logic [7:0] ctrl);
        logic [7:0] s;
        bus_read(3'd0, s);
        bus_write(3'd0, ctrl & 8'h7F);
    endtask

    task automatic t_reset;
        logic [7:0]  s;
        logic [15:0] v;
        bus_read(3'd0, s); check_eq("R1 status", {8'h0, s}, 16'h0000);
        read_cnt(v);       check_eq("R1 counter", v, 16'h0000);
        bus_read(3'd3, s); check_eq("R1 mod hi", {8'h0, s}, 16'h0000);
        bus_read(3'd4, s); check_eq("R1 mod lo", {8'h0, s}, 16'h0000);
        check_eq("R1 irq", {15'h0, irq}, 16'h0000);
    endtask

    task automatic t_edge_wrap;
        logic [7:0]  s;
        logic [15:0] v;
        bus_write(3'd0, 8'h00);
        set_mod(16'h0005);
        bus_write(3'd2, 8'h00);
        repeat (5) @(negedge clk);
        read_cnt(v); check_eq("R2 no tick holds", v, 16'h0000);
        ticks(5);
        read_cnt(v); check_eq("R2 count at modulo", v, 16'h0005);
        bus_read(3'd0, s); check_eq("R2 no flag before wrap", {8'h0, s}, 16'h0000);
        ticks(1);
        read_cnt(v); check_eq("R2 wrap to zero", v, 16'h0000);
        bus_read(3'd0, s); check_eq("R2 flag set", {8'h0, s}, 16'h0080);
        check_eq("R11 irq low when disabled", {15'h0, irq}, 16'h0000);
    endtask

    task automatic t_flag_irq;
        logic [7:0] s;
        bus_write(3'd0, 8'hC0);
        check_eq("R11 irq high", {15'h0, irq}, 16'h0001);
        bus_write(3'd0, 8'h40);
        bus_read(3'd0, s); check_eq("R10 write without read keeps flag", {8'h0, s}, 16'h00C0);
        bus_write(3'd0, 8'h40);
        bus_read(3'd0, s); check_eq("R10 flag cleared", {8'h0, s}, 16'h0040);
        check_eq("R11 irq low after clear", {15'h0, irq}, 16'h0000);
        bus_write(3'd0, 8'h00);
    endtask

    task automatic t_free_run;
        logic [7:0]  s;
        logic [15:0] v;
        set_mod(16'h0000);
        bus_write(3'd1, 8'h00);
        ticks(65535);
        read_cnt(v); check_eq("R3 reaches top", v, 16'hFFFF);
        bus_read(3'd0, s); check_eq("R3 no flag at top", {8'h0, s}, 16'h0000);
        ticks(1);
        read_cnt(v); check_eq("R3 rolls to zero", v, 16'h0000);
        bus_read(3'd0, s); check_eq("R3 flag on rollover", {8'h0, s}, 16'h0080);
        clear_flag(8'h00);
    endtask

    task automatic t_mod_lock;
        logic [7:0]  s;
        logic [15:0] v;
        set_mod(16'h0003);
        bus_write(3'd2, 8'h00);
        bus_write(3'd4, 8'h08);
        ticks(4);
        read_cnt(v); check_eq("R5 old modulo still used", v, 16'h0000);
        bus_read(3'd0, s); check_eq("R6 flag suppressed", {8'h0, s}, 16'h0000);
        bus_read(3'd4, s); check_eq("R5 mod lo not committed", {8'h0, s}, 16'h0003);
        bus_write(3'd3, 8'h00);
        bus_read(3'd4, s); check_eq("R5 mod committed", {8'h0, s}, 16'h0008);
        bus_write(3'd2, 8'h00);
        ticks(8);
        read_cnt(v); check_eq("R5 count at new modulo", v, 16'h0008);
        ticks(1);
        bus_read(3'd0, s); check_eq("R5 flag at new modulo", {8'h0, s}, 16'h0080);
        clear_flag(8'h00);
    endtask

    task automatic t_centre;
        logic [7:0]  s;
        logic [15:0] v;
        set_mod(16'h0004);
        bus_write(3'd0, 8'h20);
        bus_write(3'd1, 8'h00);
        ticks(4);
        read_cnt(v); check_eq("R4 up to modulo", v, 16'h0004);
        ticks(1);
        read_cnt(v); check_eq("R4 reverses", v, 16'h0003);
        ticks(3);
        read_cnt(v); check_eq("R4 down to zero", v, 16'h0000);
        bus_read(3'd0, s); check_eq("R4 no flag yet", {8'h0, s}, 16'h0020);
        ticks(1);
        read_cnt(v); check_eq("R4 turns up", v, 16'h0001);
        bus_read(3'd0, s); check_eq("R4 flag at zero turn", {8'h0, s}, 16'h00A0);
        bus_write(3'd0, 8'h20);
        ticks(7);
        bus_read(3'd0, s); check_eq("R4 no flag mid period", {8'h0, s}, 16'h0020);
        ticks(1);
        bus_read(3'd0, s); check_eq("R4 flag after 2xmod", {8'h0, s}, 16'h00A0);
        bus_write(3'd0, 8'h00);
    endtask

    task automatic t_coherency;
        logic [7:0] s;
        set_mod(16'h0000);
        bus_write(3'd1, 8'h00);
        ticks(300);
        bus_read(3'd1, s); check_eq("R7 live high", {8'h0, s}, 16'h0001);
        ticks(10);
        bus_read(3'd2, s); check_eq("R7 held low", {8'h0, s}, 16'h002C);
        bus_read(3'd2, s); check_eq("R8 live low", {8'h0, s}, 16'h0036);
        ticks(212);
        bus_read(3'd1, s); check_eq("R8 held high", {8'h0, s}, 16'h0001);
        bus_read(3'd2, s); check_eq("R8 released low", {8'h0, s}, 16'h000A);
        ticks(256);
        bus_read(3'd1, s); check_eq("R8 held high again", {8'h0, s}, 16'h0002);
    endtask

    task automatic t_freeze;
        logic [7:0]  s;
        logic [15:0] v;
        bus_read(3'd1, s); check_eq("R9 setup high", {8'h0, s}, 16'h0003);
        @(negedge clk); dbg_freeze = 1'b1;
        ticks(5);
        bus_read(3'd2, s); check_eq("R9 held low in freeze", {8'h0, s}, 16'h000A);
        bus_read(3'd2, s); check_eq("R9 buffer not released", {8'h0, s}, 16'h000A);
        bus_read(3'd1, s); check_eq("R9 counter stopped", {8'h0, s}, 16'h0003);
        @(negedge clk); dbg_freeze = 1'b0;
        ticks(1);
        bus_read(3'd2, s); check_eq("R9 buffer kept through freeze", {8'h0, s}, 16'h000A);
        read_cnt(v); check_eq("R9 counter resumes", v, 16'h030B);
        bus_read(3'd1, s);
        bus_write(3'd2, 8'h5A);
        bus_read(3'd2, s); check_eq("R12 buffer cleared", {8'h0, s}, 16'h0000);
        bus_read(3'd1, s); check_eq("R12 counter zeroed", {8'h0, s}, 16'h0000);
    endtask

    initial begin
        #1_500_000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_edge_wrap();
        t_flag_irq();
        t_free_run();
        t_mod_lock();
        t_centre();
        t_coherency();
        t_freeze();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule